// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches the clock and data lines of an I2C bus and reports what happens on them. It never drives either line. Both lines are brought into the system clock domain through a synchroniser chain. Each synchronised sample is then compared with the one taken on the previous clock, which finds clock rising edges and the two bus conditions. A condition is a data-line change while the clock line is high: a falling data line is a START and a rising one is a STOP.

A frame tracker moves between three states: idle, collecting the address and collecting data. It gathers nine bits per byte, with the most significant bit first and the acknowledge bit last. Each completed byte is classified as an address write, address read, data write or data read. Every event appears as a one-cycle strobe together with an event code, the decoded byte, a NACK flag and the raw nine-bit shift value.

A START that comes after an earlier START, with no STOP in between, is reported as a repeated START. The tracker checks for conditions only in certain states, so glitches at some points in a frame are ignored.

Top module: `i2c_bus_monitor`

## Requirements
- R1: With the clock line high, a data line going from 1 to 0 while the monitor is idle or collecting data gives a START event (code 0) and starts a fresh address byte.
- R2: With the clock line high, a data line going from 0 to 1 while collecting data gives a STOP event (code 2), and the monitor returns to idle.
- R3: A bit is captured on each rising edge of the clock line, most significant bit first. The ninth bit is the acknowledge bit, and evt_nack_o is 1 when that bit is 1.
- R4: The first byte after a START is the address byte. Its lowest payload bit is the direction bit. A direction bit of 0 gives code 3 (address write) and a direction bit of 1 gives code 4 (address read). evt_byte_o carries the upper seven payload bits, right-aligned, with a 0 in the top bit.
- R5: Any number of data bytes may follow the address byte. A data byte gives code 5 (data write) or code 6 (data read), chosen by the direction bit of the latest address byte, and evt_byte_o carries the full payload.
- R6: A START that follows an earlier START with no STOP in between gives code 1 (repeated START). After a STOP, the next START gives code 0 again.
- R7: While the address byte is being collected, START and STOP conditions are ignored. While idle, a STOP is ignored. In both cases the bits keep being assembled as if the condition had not occurred.
- R8: Every byte event also presents evt_raw_o, which holds the eight payload bits in bits 8..1 and the acknowledge bit in bit 0. START and STOP events present zero on evt_byte_o and evt_raw_o.
- R9: The first synchronised sample after reset only loads the stored previous line values, so no condition is detected on it. evt_valid_o is 0 during and straight after reset.
- R10: evt_valid_o is high for exactly one cycle per event. For a pin change that the bench applies between clock edges, evt_valid_o is high after the third following rising edge.
- R11: A START seen while collecting data discards any partial byte, and the next byte is assembled from a zero bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, observed only |
| sda_i | input | 1 | Bus data line, observed only |
| evt_valid_o | output | 1 | One-cycle strobe marking a reported event |
| evt_code_o | output | 3 | Event code: 0 START, 1 repeated START, 2 STOP, 3 address write, 4 address read, 5 data write, 6 data read |
| evt_byte_o | output | BYTE_W (8) | Decoded address or data byte |
| evt_nack_o | output | 1 | Acknowledge bit of the byte, 1 means NACK |
| evt_raw_o | output | BYTE_W+1 (9) | Raw shift value: payload bits followed by the acknowledge bit |

## Verification
The hardest situations to reach are the conditions that the monitor must ignore. These are a STOP or START shape that appears in the middle of the address byte, and a STOP on a bus that has just left reset. The bench builds them on purpose. During one address bit it raises the clock with the data line low and then lifts the data line. During the next bit it drops the data line while the clock is high. It then checks that the resulting address still decodes bit-exactly and that no extra event was logged. The bench also holds the data line low through reset and releases it afterwards, to show that the first sample and an idle-state STOP produce nothing.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6
  } ev_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } frame_st_e;

  // Event code for a finished byte from its role and the transfer direction.
  function automatic ev_code_e byte_code(input logic is_addr, input logic rd);
    if (is_addr) return rd ? EV_ADDR_RD : EV_ADDR_WR;
    return rd ? EV_DATA_RD : EV_DATA_WR;
  endfunction

  // Event code for a START, depending on whether a frame is already open.
  function automatic ev_code_e start_code(input logic in_frame);
    return in_frame ? EV_RSTART : EV_START;
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o,
  output logic             vld_o
);

  logic [STAGES-1:0][LANES-1:0] pipe_q;
  logic [STAGES-1:0]            fill_q;

  // The chain resets to the idle bus level. fill_q marks the stages that
  // already hold a real pin sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      fill_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      fill_q[0] <= 1'b1;
      for (int i = 1; i < int'(STAGES); i++) begin
        pipe_q[i] <= pipe_q[i-1];
        fill_q[i] <= fill_q[i-1];
      end
    end
  end

  assign q_o   = pipe_q[STAGES-1];
  assign vld_o = fill_q[STAGES-1];

endmodule

// File: rtl/i2c_mon_edge.sv
module i2c_mon_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic load_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);

  logic prev_scl_q, prev_sda_q, primed_q;
  logic live;

  assign load_o = smp_vld_i && !primed_q;
  assign live   = smp_vld_i && primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
      primed_q   <= 1'b0;
    end else if (smp_vld_i) begin
      prev_scl_q <= scl_i;
      prev_sda_q <= sda_i;
      primed_q   <= 1'b1;
    end
  end

  assign scl_rise_o = live && !prev_scl_q && scl_i;
  assign start_o    = live && scl_i && prev_sda_q && !sda_i;
  assign stop_o     = live && scl_i && !prev_sda_q && sda_i;

  AST_PRIMED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q); // R9

endmodule

// File: rtl/i2c_mon_frame.sv
module i2c_mon_frame
  import i2c_mon_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              evt_valid_o,
  output logic [2:0]        evt_code_o,
  output logic [BYTE_W-1:0] evt_byte_o,
  output logic              evt_nack_o,
  output logic [BYTE_W:0]   evt_raw_o
);

  localparam int unsigned FRAME_W = BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  // Address field: payload without its direction bit, right-aligned.
  function automatic logic [BYTE_W-1:0] addr_field(input logic [BYTE_W-1:0] p);
    return {1'b0, p[BYTE_W-1:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] payload_of(input logic [FRAME_W-1:0] r);
    return r[FRAME_W-1:1];
  endfunction

  frame_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rep_q, dir_rd_q;

  logic               take_bit, take_start, take_stop, byte_done;
  logic [FRAME_W-1:0] shift_nx;
  logic [BYTE_W-1:0]  payload;

  // Priority in the data state: bit edge, then START, then STOP.
  assign take_bit   = (st_q == ST_ADDR || st_q == ST_DATA) && bit_rise_i;
  assign take_start = start_i && ((st_q == ST_IDLE) ||
                                  (st_q == ST_DATA && !bit_rise_i));
  assign take_stop  = stop_i && st_q == ST_DATA && !bit_rise_i && !start_i;
  assign byte_done  = take_bit && (cnt_q == LAST_BIT);
  assign shift_nx   = {sh_q, sda_i};
  assign payload    = payload_of(shift_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      rep_q       <= 1'b0;
      dir_rd_q    <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_code_o  <= EV_START;
      evt_byte_o  <= '0;
      evt_nack_o  <= 1'b0;
      evt_raw_o   <= '0;
    end else begin
      evt_valid_o <= 1'b0;
      if (take_start) begin
        st_q        <= ST_ADDR;
        cnt_q       <= '0;
        sh_q        <= '0;
        rep_q       <= 1'b1;
        dir_rd_q    <= 1'b0;
        evt_valid_o <= 1'b1;
        evt_code_o  <= start_code(rep_q);
        evt_byte_o  <= '0;
        evt_nack_o  <= 1'b0;
        evt_raw_o   <= '0;
      end else if (take_stop) begin
        st_q        <= ST_IDLE;
        rep_q       <= 1'b0;
        dir_rd_q    <= 1'b0;
        evt_valid_o <= 1'b1;
        evt_code_o  <= EV_STOP;
        evt_byte_o  <= '0;
        evt_nack_o  <= 1'b0;
        evt_raw_o   <= '0;
      end else if (byte_done) begin
        cnt_q       <= '0;
        sh_q        <= '0;
        evt_valid_o <= 1'b1;
        evt_nack_o  <= shift_nx[0];
        evt_raw_o   <= shift_nx;
        if (st_q == ST_ADDR) begin
          st_q       <= ST_DATA;
          dir_rd_q   <= payload[0];
          evt_code_o <= byte_code(1'b1, payload[0]);
          evt_byte_o <= addr_field(payload);
        end else begin
          evt_code_o <= byte_code(1'b0, dir_rd_q);
          evt_byte_o <= payload;
        end
      end else if (take_bit) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= shift_nx[BYTE_W-1:0];
      end
    end
  end

  AST_START_ARMS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> (st_q == ST_ADDR) && (cnt_q == '0)); // R1
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    take_stop |=> (st_q == ST_IDLE) && !rep_q); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT); // R3
  AST_ADDR_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o && (evt_code_o == EV_ADDR_WR || evt_code_o == EV_ADDR_RD)
      |-> st_q == ST_DATA); // R4
  AST_DATA_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o && evt_code_o == EV_DATA_RD |-> dir_rd_q); // R5
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) && !bit_rise_i |=> st_q == ST_ADDR); // R7

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              evt_valid_o,
  output logic [2:0]        evt_code_o,
  output logic [BYTE_W-1:0] evt_byte_o,
  output logic              evt_nack_o,
  output logic [BYTE_W:0]   evt_raw_o
);

  localparam int unsigned LANES = 2;

  logic [LANES-1:0] line_s;
  logic             smp_vld;
  logic             first_smp, scl_rise, start_c, stop_c;

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s),
    .vld_o (smp_vld)
  );

  i2c_mon_edge i_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld_i  (smp_vld),
    .scl_i      (line_s[1]),
    .sda_i      (line_s[0]),
    .load_o     (first_smp),
    .scl_rise_o (scl_rise),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_mon_frame #(.BYTE_W(BYTE_W)) i_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_rise_i  (scl_rise),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .sda_i       (line_s[0]),
    .evt_valid_o (evt_valid_o),
    .evt_code_o  (evt_code_o),
    .evt_byte_o  (evt_byte_o),
    .evt_nack_o  (evt_nack_o),
    .evt_raw_o   (evt_raw_o)
  );

  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    first_smp |=> !evt_valid_o); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> evt_code_o <= 3'd6); // R10

endmodule

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       evt_valid;
  logic [2:0] evt_code;
  logic [7:0] evt_byte;
  logic       evt_nack;
  logic [8:0] evt_raw;

  int n_chk = 0;
  int n_bad = 0;
  int n_ev  = 0;
  bit done  = 1'b0;

  logic [2:0] ev_code [64];
  logic [7:0] ev_byte [64];
  logic       ev_nack [64];
  logic [8:0] ev_raw  [64];

  always #5 clk = ~clk;

  i2c_bus_monitor i_i2c_bus_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda),
    .evt_valid_o (evt_valid),
    .evt_code_o  (evt_code),
    .evt_byte_o  (evt_byte),
    .evt_nack_o  (evt_nack),
    .evt_raw_o   (evt_raw)
  );

  always @(negedge clk) begin
    if (rst_n && evt_valid && n_ev < 64) begin
      ev_code[n_ev] = evt_code;
      ev_byte[n_ev] = evt_byte;
      ev_nack[n_ev] = evt_nack;
      ev_raw[n_ev]  = evt_raw;
      n_ev++;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_count(input int exp, input string req);
    check(n_ev == exp, req, "event count", n_ev, exp);
  endtask

  // Expected fields packed as {code, byte, nack, raw}.
  task automatic check_ev(input int idx, input int code, input int byt,
                          input int nack, input int raw, input string req);
    logic [20:0] exp_v, act_v;
    exp_v = {code[2:0], byt[7:0], nack[0], raw[8:0]};
    act_v = (idx < n_ev) ? {ev_code[idx], ev_byte[idx], ev_nack[idx], ev_raw[idx]}
                         : 21'h1fffff;
    check(act_v == exp_v, req, $sformatf("event %0d {code,byte,nack,raw}", idx),
          int'(act_v), int'(exp_v));
  endtask

  // Raw value expected for a byte: payload then acknowledge bit.
  function automatic int raw_of(input logic [7:0] v, input logic ack);
    return int'({v, ack});
  endfunction

  task automatic send_bit(input logic b);
    sda = b;  hold(H);
    scl = 1'b1; hold(H);
    scl = 1'b0; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  task automatic do_start;
    sda = 1'b0; hold(H);
    scl = 1'b0; hold(H);
  endtask

  task automatic do_rstart;
    sda = 1'b1; hold(H);
    scl = 1'b1; hold(H);
    sda = 1'b0; hold(H);
    scl = 1'b0; hold(H);
  endtask

  task automatic do_stop;
    sda = 1'b0; hold(H);
    scl = 1'b1; hold(H);
    sda = 1'b1; hold(2 * H);
  endtask

  // Reset state, first sample, idle STOP, latency, write transfer.
  task automatic t_reset_and_write;
    scl = 1'b1; sda = 1'b0;
    hold(5);
    check(evt_valid == 1'b0, "R9", "valid in reset", evt_valid, 0);
    rst_n = 1'b1;
    hold(10);
    check_count(0, "R9");
    sda = 1'b1; hold(10);
    check_count(0, "R7");
    sda = 1'b0;
    hold(1); check(evt_valid == 1'b0, "R10", "valid after 1 edge", evt_valid, 0);
    hold(1); check(evt_valid == 1'b0, "R10", "valid after 2 edges", evt_valid, 0);
    hold(1); check(evt_valid == 1'b1 && evt_code == 3'd0, "R1", "start after 3 edges",
                   {evt_valid, evt_code}, 4'b1000);
    hold(1); check(evt_valid == 1'b0, "R10", "valid width", evt_valid, 0);
    scl = 1'b0; hold(H);
    send_byte(8'hA4, 1'b0);
    send_byte(8'h3C, 1'b1);
    send_byte(8'h81, 1'b0);
    do_stop;
    check_ev(1, 3, 8'h52, 0, raw_of(8'hA4, 1'b0), "R4");
    check_ev(2, 5, 8'h3C, 1, raw_of(8'h3C, 1'b1), "R3");
    check_ev(3, 5, 8'h81, 0, raw_of(8'h81, 1'b0), "R8");
    check_ev(4, 2, 0, 0, 0, "R2");
    check_count(5, "R2");
  endtask

  // Read transfer, repeated START, direction switch.
  task automatic t_read_and_restart;
    int base;
    base = n_ev;
    do_start;
    send_byte(8'h57, 1'b0);
    send_byte(8'hF0, 1'b1);
    do_rstart;
    send_byte(8'hA0, 1'b0);
    send_byte(8'h11, 1'b0);
    do_stop;
    check_ev(base + 0, 0, 0, 0, 0, "R6");
    check_ev(base + 1, 4, 8'h2B, 0, raw_of(8'h57, 1'b0), "R4");
    check_ev(base + 2, 6, 8'hF0, 1, raw_of(8'hF0, 1'b1), "R5");
    check_ev(base + 3, 1, 0, 0, 0, "R6");
    check_ev(base + 4, 3, 8'h50, 0, raw_of(8'hA0, 1'b0), "R4");
    check_ev(base + 5, 5, 8'h11, 0, raw_of(8'h11, 1'b0), "R5");
    check_ev(base + 6, 2, 0, 0, 0, "R2");
    check_count(base + 7, "R6");
  endtask

  // Partial data byte cut short by a repeated START.
  task automatic t_partial_byte;
    int base;
    base = n_ev;
    do_start;
    send_byte(8'h90, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    do_rstart;
    send_byte(8'hC3, 1'b1);
    do_stop;
    check_ev(base + 0, 0, 0, 0, 0, "R1");
    check_ev(base + 1, 3, 8'h48, 0, raw_of(8'h90, 1'b0), "R4");
    check_ev(base + 2, 1, 0, 0, 0, "R11");
    check_ev(base + 3, 4, 8'h61, 1, raw_of(8'hC3, 1'b1), "R11");
    check_ev(base + 4, 2, 0, 0, 0, "R2");
    check_count(base + 5, "R11");
  endtask

  // STOP and START shapes inside the address byte are ignored.
  task automatic t_addr_filter;
    int base;
    logic [7:0] rest;
    base = n_ev;
    rest = 8'h6A;
    do_start;
    sda = 1'b0; hold(H); scl = 1'b1; hold(H);
    sda = 1'b1; hold(H); scl = 1'b0; hold(H);
    sda = 1'b1; hold(H); scl = 1'b1; hold(H);
    sda = 1'b0; hold(H); scl = 1'b0; hold(H);
    for (int i = 5; i >= 0; i--) send_bit(rest[i]);
    send_bit(1'b0);
    check_count(base + 2, "R7");
    do_stop;
    check_ev(base + 0, 0, 0, 0, 0, "R1");
    check_ev(base + 1, 3, 8'h35, 0, raw_of(8'h6A, 1'b0), "R7");
    check_ev(base + 2, 2, 0, 0, 0, "R2");
    check_count(base + 3, "R7");
  endtask

  initial begin
    t_reset_and_write;
    t_read_and_restart;
    t_partial_byte;
    t_addr_filter;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule